// File: doc/BRIEF.md
# Direct-Mapped Instruction Fetch Cache

This block sits between a processor's instruction fetch port and a word-wide memory read port. A fetch presents a 32-bit byte address. The block returns one 32-bit instruction word, and it holds a stall output while it is busy. The top address byte selects a region. Only two region codes are served from the cache. Every other code goes straight to memory with a single word read and leaves the cache unchanged.

The cache holds 4 KiB of instruction words, indexed by address bits [11:0]. Every word has its own tag, which is the low 24 bits of that word's address. On a miss in a cacheable region, the block fetches the whole aligned four-word line from memory and writes it into the arrays. The word handed back on a miss is the memory word at the requested address. An isolate input stops a miss from changing the arrays. A flush input returns every entry to the all-ones empty state, and the same clear sweep runs after reset. Memory writes are never observed by the block, so an address that still hits keeps returning the word cached earlier.

Top module: `fetch_icache`

## Requirements
- R1: A fetch whose address bits [31:24] are 0xA0 or higher is served by exactly one memory read of that address. It does not change the arrays, so a later cacheable fetch with the same low 24 bits still misses.
- R2: Region codes below 0xA0 other than 0x00 and 0x80 are also uncached. Each such fetch makes one memory read, however often it repeats.
- R3: A fetch in region 0x00 or 0x80 hits when the tag stored for address bits [11:2] equals address bits [23:0]. A hit makes no memory read, and fetch_rdy carries the cached word in the cycle after the fetch is accepted.
- R4: A cacheable miss without isolate reads the aligned line (address with bits [3:0] cleared, plus 0, 4, 8 and 12) and writes all four words and tags. Afterwards every word of that line hits, whichever of region 0x00 or 0x80 it is fetched through. A line sharing the index but differing in bits [23:12] evicts it.
- R5: The word returned on any miss equals the memory word at the requested address, including when the request falls in the middle of a line.
- R6: When isolate is high at acceptance, a cacheable miss makes one memory read of the requested address and leaves the arrays unchanged. Isolate has no effect on a hit.
- R7: After reset, and after flush is sampled high while idle, fetch_stall stays high while the block walks all lines (one line per cycle, 256 cycles by default). Every entry misses afterwards.
- R8: A change of memory contents after a line is filled is not seen by later hits to that line. New misses return the new contents.
- R9: fetch_stall is high from the cycle after a missed fetch is accepted until fetch_rdy is given. mem_req is only asserted while fetch_stall is high.
- R10: mem_req is held with a stable mem_addr until mem_ack. The reads of a fill go in increasing address order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_req | input | 1 | Fetch request, accepted in a cycle where fetch_stall is low |
| fetch_addr | input | 32 | Fetch byte address |
| isolate | input | 1 | Suppresses line fills for the accepted fetch |
| flush | input | 1 | Invalidate all entries |
| fetch_stall | output | 1 | Block busy; requests are not accepted |
| fetch_rdy | output | 1 | One-cycle pulse: fetch_word is valid |
| fetch_word | output | 32 | Returned instruction word |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 32 | Memory read address |
| mem_ack | input | 1 | Memory read completes this cycle |
| mem_rdata | input | 32 | Memory read data, valid with mem_ack |

## Verification
The bench drives inputs and samples outputs on falling edges. A fetch applied before edge k is accepted at k. A hit pulses fetch_rdy before the next falling edge, so the bench requires a latency of exactly one sample for hits. A miss raises fetch_stall at that same first sample. The result then follows the last memory acknowledge by one edge, so the bench polls fetch_rdy and compares the word, the number of memory reads and their address order against a behavioural tag and data model. A flush is counted sample by sample: stall must fall after exactly one sample per line.

// File: rtl/icache_pkg.sv
package icache_pkg;

  typedef enum logic [1:0] {
    ST_CLEAR  = 2'd0,
    ST_IDLE   = 2'd1,
    ST_FILL   = 2'd2,
    ST_DIRECT = 2'd3
  } ic_state_e;

endpackage

// File: rtl/icache_region_decode.sv
module icache_region_decode #(
  parameter int                   ADDR_W        = 32,
  parameter int                   REGION_W      = 8,
  parameter logic [REGION_W-1:0]  RGN_LOW       = 8'h00,
  parameter logic [REGION_W-1:0]  RGN_HIGH      = 8'h80,
  parameter logic [REGION_W-1:0]  UNCACHED_FROM = 8'hA0
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              cacheable
);

  localparam int RGN_LSB = ADDR_W - REGION_W;

  logic [REGION_W-1:0] region;
  logic                below_uncached;
  logic                code_match;

  always_comb begin
    region         = addr[ADDR_W-1:RGN_LSB];
    below_uncached = region < UNCACHED_FROM;
    code_match     = (region == RGN_LOW) || (region == RGN_HIGH);
    cacheable      = below_uncached && code_match;
  end

endmodule

// File: rtl/icache_array.sv
module icache_array #(
  parameter int LINES      = 256,
  parameter int LINE_WORDS = 4,
  parameter int TAG_W      = 24,
  parameter int DATA_W     = 32
) (
  input  logic                          clk,
  input  logic [$clog2(LINES)-1:0]      rd_line,
  input  logic [$clog2(LINE_WORDS)-1:0] rd_word,
  input  logic [TAG_W-1:0]              lk_tag,
  output logic                          lk_hit,
  output logic [DATA_W-1:0]             lk_data,
  input  logic                          clr_en,
  input  logic [$clog2(LINES)-1:0]      clr_line,
  input  logic                          wr_en,
  input  logic [$clog2(LINES)-1:0]      wr_line,
  input  logic [$clog2(LINE_WORDS)-1:0] wr_word,
  input  logic [TAG_W-1:0]              wr_tag,
  input  logic [DATA_W-1:0]             wr_data
);

  localparam int WSEL_W  = $clog2(LINE_WORDS);
  localparam int ENTRY_W = TAG_W + 1;

  // Tag entries carry one guard bit above the stored offset: cleared
  // entries are all ones, written entries have the guard bit low.
  logic [ENTRY_W-1:0] col_tag [LINE_WORDS];
  logic [DATA_W-1:0]  col_dat [LINE_WORDS];

  for (genvar w = 0; w < LINE_WORDS; w++) begin : g_col
    logic [ENTRY_W-1:0] tag_mem [LINES];
    logic [DATA_W-1:0]  dat_mem [LINES];
    logic               col_wr;

    assign col_wr = wr_en && (wr_word == WSEL_W'(w));

    always_ff @(posedge clk) begin
      if (clr_en) begin
        tag_mem[clr_line] <= '1;
        dat_mem[clr_line] <= '1;
      end else if (col_wr) begin
        tag_mem[wr_line] <= {1'b0, wr_tag};
        dat_mem[wr_line] <= wr_data;
      end
    end

    assign col_tag[w] = tag_mem[rd_line];
    assign col_dat[w] = dat_mem[rd_line];
  end

  always_comb begin
    lk_hit  = col_tag[rd_word] == {1'b0, lk_tag};
    lk_data = col_dat[rd_word];
  end

endmodule

// File: rtl/icache_ctrl.sv
module icache_ctrl
  import icache_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int LINES      = 256,
  parameter int LINE_WORDS = 4,
  parameter int TAG_W      = 24
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          fetch_req,
  input  logic [ADDR_W-1:0]             fetch_addr,
  input  logic                          isolate,
  input  logic                          flush,
  input  logic                          cacheable,
  input  logic                          hit,
  input  logic [DATA_W-1:0]             hit_data,
  output logic                          fetch_stall,
  output logic                          fetch_rdy,
  output logic [DATA_W-1:0]             fetch_word,
  output logic                          mem_req,
  output logic [ADDR_W-1:0]             mem_addr,
  input  logic                          mem_ack,
  input  logic [DATA_W-1:0]             mem_rdata,
  output logic                          clr_en,
  output logic [$clog2(LINES)-1:0]      clr_line,
  output logic                          wr_en,
  output logic [$clog2(LINES)-1:0]      wr_line,
  output logic [$clog2(LINE_WORDS)-1:0] wr_word,
  output logic [TAG_W-1:0]              wr_tag,
  output logic [DATA_W-1:0]             wr_data,
  output logic                          filling,
  output logic                          flush_pend
);

  localparam int LINE_W    = $clog2(LINES);
  localparam int WSEL_W    = $clog2(LINE_WORDS);
  localparam int BYTE_W    = $clog2(DATA_W / 8);
  localparam int OFF_W     = WSEL_W + BYTE_W;
  localparam int INDEX_W   = LINE_W + OFF_W;
  localparam logic [LINE_W-1:0] LAST_LINE = LINE_W'(LINES - 1);
  localparam logic [WSEL_W-1:0] LAST_BEAT = WSEL_W'(LINE_WORDS - 1);

  ic_state_e            state_q, state_d;
  logic [WSEL_W-1:0]    beat_q, beat_d;
  logic [LINE_W-1:0]    clr_q, clr_d;
  logic                 pend_q, pend_d;
  logic                 rdy_q, rdy_d;
  logic [ADDR_W-1:0]    addr_q;
  logic                 addr_en;
  logic [DATA_W-1:0]    word_q, word_d;
  logic                 word_en;
  logic [WSEL_W-1:0]    req_word;

  assign req_word = addr_q[OFF_W-1:BYTE_W];

  // next-state logic
  always_comb begin
    state_d = state_q;
    beat_d  = beat_q;
    clr_d   = clr_q;
    pend_d  = pend_q;
    rdy_d   = 1'b0;
    addr_en = 1'b0;
    word_en = 1'b0;
    word_d  = word_q;
    clr_en  = 1'b0;
    wr_en   = 1'b0;
    mem_req = 1'b0;
    mem_addr = addr_q;

    if (flush && (state_q == ST_FILL || state_q == ST_DIRECT)) begin
      pend_d = 1'b1;
    end

    case (state_q)
      ST_CLEAR: begin
        clr_en = 1'b1;
        if (clr_q == LAST_LINE) begin
          state_d = ST_IDLE;
          clr_d   = '0;
        end else begin
          clr_d = clr_q + 1'b1;
        end
      end
      ST_IDLE: begin
        if (flush || pend_q) begin
          state_d = ST_CLEAR;
          clr_d   = '0;
          pend_d  = 1'b0;
        end else if (fetch_req) begin
          addr_en = 1'b1;
          if (cacheable && hit) begin
            rdy_d   = 1'b1;
            word_en = 1'b1;
            word_d  = hit_data;
          end else if (cacheable && !isolate) begin
            state_d = ST_FILL;
            beat_d  = '0;
          end else begin
            state_d = ST_DIRECT;
          end
        end
      end
      ST_FILL: begin
        mem_req  = 1'b1;
        mem_addr = {addr_q[ADDR_W-1:OFF_W], beat_q, {BYTE_W{1'b0}}};
        if (mem_ack) begin
          wr_en  = 1'b1;
          beat_d = beat_q + 1'b1;
          if (beat_q == req_word) begin
            word_en = 1'b1;
            word_d  = mem_rdata;
          end
          if (beat_q == LAST_BEAT) begin
            state_d = ST_IDLE;
            rdy_d   = 1'b1;
          end
        end
      end
      ST_DIRECT: begin
        mem_req = 1'b1;
        if (mem_ack) begin
          word_en = 1'b1;
          word_d  = mem_rdata;
          rdy_d   = 1'b1;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_CLEAR;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_CLEAR;
      beat_q  <= '0;
      clr_q   <= '0;
      pend_q  <= 1'b0;
      rdy_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      beat_q  <= beat_d;
      clr_q   <= clr_d;
      pend_q  <= pend_d;
      rdy_q   <= rdy_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (addr_en) begin
      addr_q <= fetch_addr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
    end else if (word_en) begin
      word_q <= word_d;
    end
  end

  always_comb begin
    clr_line    = clr_q;
    wr_line     = addr_q[INDEX_W-1:OFF_W];
    wr_word     = beat_q;
    wr_tag      = {addr_q[TAG_W-1:OFF_W], beat_q, {BYTE_W{1'b0}}};
    wr_data     = mem_rdata;
    fetch_stall = state_q != ST_IDLE;
    fetch_rdy   = rdy_q;
    fetch_word  = word_q;
    filling     = state_q == ST_FILL;
    flush_pend  = pend_q;
  end

endmodule

// File: rtl/fetch_icache.sv
module fetch_icache #(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int CACHE_BYTES = 4096,
  parameter int LINE_WORDS  = 4,
  parameter int TAG_W       = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch_req,
  input  logic [ADDR_W-1:0] fetch_addr,
  input  logic              isolate,
  input  logic              flush,
  output logic              fetch_stall,
  output logic              fetch_rdy,
  output logic [DATA_W-1:0] fetch_word,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata
);

  localparam int WORD_BYTES = DATA_W / 8;
  localparam int LINES      = CACHE_BYTES / (LINE_WORDS * WORD_BYTES);
  localparam int LINE_W     = $clog2(LINES);
  localparam int WSEL_W     = $clog2(LINE_WORDS);
  localparam int BYTE_W     = $clog2(WORD_BYTES);
  localparam int OFF_W      = WSEL_W + BYTE_W;
  localparam int INDEX_W    = LINE_W + OFF_W;

  // reset: asserted asynchronously, released after two clock edges
  logic rst_meta_q, rst_sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  logic                lk_cacheable;
  logic                lk_hit;
  logic [DATA_W-1:0]   lk_data;
  logic                filling;
  logic                flush_pend;
  logic                clr_en;
  logic [LINE_W-1:0]   clr_line;
  logic                wr_en;
  logic [LINE_W-1:0]   wr_line;
  logic [WSEL_W-1:0]   wr_word;
  logic [TAG_W-1:0]    wr_tag;
  logic [DATA_W-1:0]   wr_data;

  icache_region_decode #(
    .ADDR_W (ADDR_W)
  ) u_region (
    .addr      (fetch_addr),
    .cacheable (lk_cacheable)
  );

  icache_array #(
    .LINES      (LINES),
    .LINE_WORDS (LINE_WORDS),
    .TAG_W      (TAG_W),
    .DATA_W     (DATA_W)
  ) u_array (
    .clk      (clk),
    .rd_line  (fetch_addr[INDEX_W-1:OFF_W]),
    .rd_word  (fetch_addr[OFF_W-1:BYTE_W]),
    .lk_tag   (fetch_addr[TAG_W-1:0]),
    .lk_hit   (lk_hit),
    .lk_data  (lk_data),
    .clr_en   (clr_en),
    .clr_line (clr_line),
    .wr_en    (wr_en),
    .wr_line  (wr_line),
    .wr_word  (wr_word),
    .wr_tag   (wr_tag),
    .wr_data  (wr_data)
  );

  icache_ctrl #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .LINES      (LINES),
    .LINE_WORDS (LINE_WORDS),
    .TAG_W      (TAG_W)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_sync_q),
    .fetch_req   (fetch_req),
    .fetch_addr  (fetch_addr),
    .isolate     (isolate),
    .flush       (flush),
    .cacheable   (lk_cacheable),
    .hit         (lk_hit),
    .hit_data    (lk_data),
    .fetch_stall (fetch_stall),
    .fetch_rdy   (fetch_rdy),
    .fetch_word  (fetch_word),
    .mem_req     (mem_req),
    .mem_addr    (mem_addr),
    .mem_ack     (mem_ack),
    .mem_rdata   (mem_rdata),
    .clr_en      (clr_en),
    .clr_line    (clr_line),
    .wr_en       (wr_en),
    .wr_line     (wr_line),
    .wr_word     (wr_word),
    .wr_tag      (wr_tag),
    .wr_data     (wr_data),
    .filling     (filling),
    .flush_pend  (flush_pend)
  );

endmodule

// File: rtl/fetch_icache_checker.sv
module fetch_icache_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fetch_req,
  input logic              flush,
  input logic              fetch_stall,
  input logic              fetch_rdy,
  input logic              mem_req,
  input logic              mem_ack,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              lk_cacheable,
  input logic              lk_hit,
  input logic              filling,
  input logic              flush_pend
);

  AST_HIT_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req && !fetch_stall && !flush && !flush_pend && lk_cacheable && lk_hit
    |=> fetch_rdy && !fetch_stall); // R3

  AST_UNCACHED_DIRECT: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req && !fetch_stall && !flush && !flush_pend && !lk_cacheable
    |=> mem_req && !filling); // R1

  AST_FILL_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    filling && mem_ack && (mem_addr[3:2] != 2'b11)
    |=> mem_req && (mem_addr == $past(mem_addr) + 32'd4)); // R4

  AST_FLUSH_SWEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (flush || flush_pend) && !fetch_stall |=> fetch_stall); // R7

  AST_IDLE_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_stall |-> !mem_req); // R9

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr)); // R10

endmodule

bind fetch_icache fetch_icache_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .fetch_req    (fetch_req),
  .flush        (flush),
  .fetch_stall  (fetch_stall),
  .fetch_rdy    (fetch_rdy),
  .mem_req      (mem_req),
  .mem_ack      (mem_ack),
  .mem_addr     (mem_addr),
  .lk_cacheable (lk_cacheable),
  .lk_hit       (lk_hit),
  .filling      (filling),
  .flush_pend   (flush_pend)
);

// File: tb/fetch_icache_bench.sv
`timescale 1ns/1ps
module fetch_icache_bench;

  localparam int LINES = 256;
  localparam int NENT  = 1024;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        fetch_req, isolate, flush;
  logic [31:0] fetch_addr;
  logic        fetch_stall, fetch_rdy;
  logic [31:0] fetch_word;
  logic        mem_req, mem_ack;
  logic [31:0] mem_addr, mem_rdata;

  int n_checks = 0;
  int n_err    = 0;
  int mem_lat  = 0;
  int rd_cnt   = 0;
  logic [31:0] gen_key = 32'h0;
  logic [31:0] rd_log [8];

  logic [24:0] ref_tag [NENT];
  logic [31:0] ref_dat [NENT];

  always #4 clk = ~clk;

  fetch_icache u_fetch_icache (
    .clk(clk), .rst_n(rst_n), .fetch_req(fetch_req), .fetch_addr(fetch_addr),
    .isolate(isolate), .flush(flush), .fetch_stall(fetch_stall),
    .fetch_rdy(fetch_rdy), .fetch_word(fetch_word), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  function automatic logic [31:0] memf(input logic [31:0] a);
    return ({a[31:2], 2'b00} * 32'h9E3779B1) ^ gen_key;
  endfunction

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic ref_clear();
    for (int i = 0; i < NENT; i++) begin
      ref_tag[i] = '1;
      ref_dat[i] = '1;
    end
  endtask

  // memory model: acknowledges after mem_lat waiting samples
  initial begin
    int waitc;
    waitc = 0;
    mem_ack = 1'b0;
    mem_rdata = '0;
    forever begin
      @(negedge clk);
      if (mem_ack) begin
        mem_ack = 1'b0;
        waitc = 0;
      end else if (mem_req) begin
        if (waitc >= mem_lat) begin
          mem_ack = 1'b1;
          mem_rdata = memf(mem_addr);
          if (rd_cnt < 8) rd_log[rd_cnt] = mem_addr;
          rd_cnt++;
        end else begin
          waitc++;
        end
      end
    end
  end

  task automatic do_fetch(input logic [31:0] a, input logic iso, input string req);
    logic        cach, hit, fill;
    int          idx, exp_rd, lat;
    logic [31:0] exp_w, base, b;
    logic        st1;
    cach = (a[31:24] == 8'h00) || (a[31:24] == 8'h80);
    idx  = int'(a[11:2]);
    hit  = cach && (ref_tag[idx] == {1'b0, a[23:0]});
    fill = cach && !hit && !iso;
    base = {a[31:4], 4'h0};
    if (hit) begin
      exp_w = ref_dat[idx];
      exp_rd = 0;
    end else begin
      exp_w = memf(a);
      exp_rd = fill ? 4 : 1;
    end
    if (fill) begin
      for (int k = 0; k < 4; k++) begin
        b = base + 32'(4 * k);
        ref_tag[int'(b[11:2])] = {1'b0, b[23:0]};
        ref_dat[int'(b[11:2])] = memf(b);
      end
    end
    @(negedge clk);
    while (fetch_stall) @(negedge clk);
    fetch_addr = a;
    isolate = iso;
    fetch_req = 1'b1;
    rd_cnt = 0;
    @(negedge clk);
    fetch_req = 1'b0;
    lat = 1;
    st1 = fetch_stall;
    while (!fetch_rdy && lat < 2000) begin
      @(negedge clk);
      lat++;
    end
    check(fetch_rdy, "R9 response", {31'b0, fetch_rdy}, 32'h1);
    check(fetch_word == exp_w, hit ? "R3 hit word" : "R5 miss word", fetch_word, exp_w);
    check(rd_cnt == exp_rd, req, rd_cnt, exp_rd);
    if (hit) check(lat == 1, "R3 hit latency", lat, 1);
    else     check(st1 == 1'b1, "R9 stall on miss", {31'b0, st1}, 32'h1);
    if (fill && rd_cnt == 4) begin
      for (int k = 0; k < 4; k++)
        check(rd_log[k] == base + 32'(4 * k), "R10 fill order", rd_log[k], base + 32'(4 * k));
    end else if (exp_rd == 1 && rd_cnt == 1) begin
      check(rd_log[0] == a, "R1 direct address", rd_log[0], a);
    end
  endtask

  task automatic do_flush();
    int cnt;
    @(negedge clk);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    check(fetch_stall == 1'b1, "R7 stall after flush", {31'b0, fetch_stall}, 32'h1);
    cnt = 0;
    while (fetch_stall && cnt < 5000) begin
      @(negedge clk);
      cnt++;
    end
    check(cnt == LINES, "R7 sweep length", cnt, LINES);
    ref_clear();
  endtask

  initial begin
    #1500000;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin
    logic [31:0] a;
    rst_n = 1'b0;
    fetch_req = 1'b0;
    fetch_addr = '0;
    isolate = 1'b0;
    flush = 1'b0;
    ref_clear();
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(fetch_stall == 1'b1, "R7 reset stall", {31'b0, fetch_stall}, 32'h1);
    check(fetch_rdy == 1'b0, "R7 reset rdy", {31'b0, fetch_rdy}, 32'h0);
    check(mem_req == 1'b0, "R9 reset mem_req", {31'b0, mem_req}, 32'h0);

    // R4 / R3: four lines word by word, then again
    for (int pass = 0; pass < 2; pass++)
      for (int w = 0; w < 16; w++) begin
        mem_lat = w % 3;
        do_fetch(32'h0000_0100 + 32'(4 * w), 1'b0, "R4 line reads");
      end
    do_fetch(32'h8000_0104, 1'b0, "R4 alias region hit");
    // R4: conflicting tag evicts
    do_fetch(32'h0000_2100, 1'b0, "R4 conflict fill");
    do_fetch(32'h0000_0100, 1'b0, "R4 evicted refill");
    // R5: mid-line request
    do_fetch(32'h0000_0248, 1'b0, "R5 mid-line fill");
    do_fetch(32'h0000_0244, 1'b0, "R5 neighbour hit");
    // R1: high regions
    do_fetch(32'hA000_0300, 1'b0, "R1 uncached read");
    do_fetch(32'hBFC0_0304, 1'b0, "R1 uncached read");
    do_fetch(32'hFF00_0308, 1'b0, "R1 uncached read");
    do_fetch(32'h0000_0300, 1'b0, "R1 no fill left behind");
    // R2: other low regions
    do_fetch(32'h1F00_0400, 1'b0, "R2 bypass read");
    do_fetch(32'h7F00_0400, 1'b0, "R2 bypass read");
    do_fetch(32'h9F00_0404, 1'b0, "R2 bypass read");
    do_fetch(32'h1F00_0400, 1'b0, "R2 repeat bypass");
    // R6: isolate
    do_fetch(32'h0000_0500, 1'b1, "R6 isolated miss");
    do_fetch(32'h0000_0500, 1'b1, "R6 still missing");
    do_fetch(32'h0000_0500, 1'b0, "R6 fill when released");
    do_fetch(32'h0000_0504, 1'b1, "R6 hit under isolate");
    // R8: stale contents after memory change
    gen_key = 32'h5A5A_1234;
    do_fetch(32'h0000_0100, 1'b0, "R8 stale hit");
    do_fetch(32'h0000_0600, 1'b0, "R8 new miss");
    // R7: flush
    do_flush();
    do_fetch(32'h0000_0100, 1'b0, "R7 miss after flush");
    do_fetch(32'h0000_0600, 1'b0, "R7 miss after flush");
    // near-exhaustive mixed sweep with index collisions
    for (int i = 0; i < 120; i++) begin
      mem_lat = i % 3;
      a = 32'(((i * 37) % 64) * 4) + 32'((i % 4) * 32'h1000);
      if (i % 5 == 0) a[31:24] = 8'h80;
      else if (i % 11 == 7) a[31:24] = 8'hC0;
      if (i == 60) gen_key = 32'h0F0F_A5A5;
      do_fetch(a, (i % 9 == 4), "R4 mixed sweep");
    end
    do_flush();
    do_fetch(32'h8000_0000, 1'b0, "R7 miss after second flush");

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

endmodule